// File: doc/BRIEF.md
# Transition Encoded Modulation Frame Encoder

This block compresses a slow binary data line into one 8-bit code word per 125 µs frame. Each frame is cut into 32 timeslots of eight system clock cycles each. Rather than sampling the line level, the encoder notes in which timeslot each level change falls, how many changes there were and how far apart they were. It then picks one of a small set of typed word formats that says all of that in eight bits. A separate strobe flags a violation pulse, which marks a point in time without changing the level, and this pulse can be coded when the frame holds no data transition.

A frame strobe aligns the timeslot counter. Once started, the counter runs freely and closes a frame every 256 cycles whether or not further strobes arrive. A strobe that comes before a frame has finished throws that frame away and starts a new one. The word is presented for one cycle after the last cycle of timeslot 31. Serial shifting onto a time-division bus and line-code conversion belong to other blocks.

Top module: `tem_encoder`

## Requirements
- R1: While reset is asserted and after its release, `word_valid` is 0 and `word` is 8'h00 until the first frame ends.
- R2: A `frame_start` pulse marks cycle 0 of timeslot 0. Each timeslot lasts 8 cycles and a frame lasts 32 timeslots. `word_valid` is high for exactly one cycle, the cycle after the last cycle of timeslot 31. No word is produced before the first strobe. Without further strobes, frames repeat every 256 cycles.
- R3: Bit 7 of the word is the `data_in` level in the last cycle of the frame.
- R4: A frame with no transition and no violation pulse gives bits 6..5 = 11 and bits 4..0 = 11111.
- R5: A frame with exactly one transition gives bits 6..5 = 10, with bits 4..0 holding the timeslot of that transition (0 to 31). A transition is a cycle whose `data_in` differs from the previous cycle's.
- R6: A frame with violation pulses but no transition gives bits 6..5 = 10, with bits 4..0 holding the timeslot of the first violation. When the frame also holds a transition, the violations have no effect on the word.
- R7: Two transitions 12 to 14 timeslots apart, with the first in timeslot 17 or lower, give bits 6..5 = 11 and bits 4..0 = first timeslot.
- R8: Three transitions with both gaps 12 to 14 timeslots, and the first in timeslot 4 or lower, give bits 6..5 = 11 and bits 4..0 = first timeslot.
- R9: Two transitions 26 to 28 timeslots apart, with the first in timeslot 4 or higher, give bits 6..5 = 01 and bits 4..0 = first timeslot.
- R10: Two transitions 26 to 28 timeslots apart, with the first in timeslot 0 to 3, give bits 6..5 = 00. Bits 4..2 hold the second timeslot minus 24, and bits 1..0 hold the first timeslot.
- R11: Any other pattern is coded as a single transition (bits 6..5 = 10, bits 4..0 = first transition's timeslot). This covers a gap outside both windows, a first position beyond its limit, and four or more transitions.
- R12: A `frame_start` that arrives before a frame has ended discards that partial frame without emitting a word, and the count restarts at timeslot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8 cycles per timeslot |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame alignment strobe, marks cycle 0 of timeslot 0 |
| data_in | input | 1 | Sampled binary data level |
| viol_in | input | 1 | One-cycle strobe marking a violation pulse |
| word | output | 8 | Coded frame word, held until the next frame ends |
| word_valid | output | 1 | One-cycle strobe when `word` is new |

## Verification
A wrong timeslot counter shows up as a wrong position field at the end of the first frame whose transitions sit near a slot boundary. It also shows as a `word_valid` pulse that is early, late or missing, and that is visible within 256 cycles. A wrong edge record (a missed, doubled or misordered transition, or a violation kept when it should be dropped) shows up as the wrong frame type in the very next word. For that reason each frame type is driven at the positions just inside and just outside its limits: timeslots 0, 3, 4, 17, 18 and 31, and gaps at the edges of the tolerance windows. A stale record left over from a discarded partial frame would corrupt the word of the frame that follows it.

// File: rtl/tem_pkg.sv
package tem_pkg;
   localparam int SLOT_W = 5;
   localparam int CNT_W  = 3;

   typedef struct packed {
      logic [CNT_W-1:0]  n_edges;
      logic [SLOT_W-1:0] pos1;
      logic [SLOT_W-1:0] pos2;
      logic [SLOT_W-1:0] pos3;
      logic              viol_seen;
      logic [SLOT_W-1:0] viol_pos;
      logic              level;
   } tem_summary_t;
endpackage

// File: rtl/tem_slot_timer.sv
module tem_slot_timer #(
   parameter int SLOT_CYC = 8,
   parameter int SLOTS    = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_start,
   output logic                     active,
   output logic                     first,
   output logic                     last,
   output logic [$clog2(SLOTS)-1:0] slot
);
   localparam int CYC_W = $clog2(SLOT_CYC);
   localparam int SW    = $clog2(SLOTS);
   localparam logic [CYC_W-1:0] CYC_LAST  = CYC_W'(SLOT_CYC - 1);
   localparam logic [SW-1:0]    SLOT_LAST = SW'(SLOTS - 1);

   if (SLOT_CYC < 2) begin : g_bad_cyc
      $error("SLOT_CYC must be at least 2");
   end
   if (SLOTS != (1 << SW)) begin : g_bad_slots
      $error("SLOTS must be a power of two");
   end

   logic [CYC_W-1:0] cyc_q, cur_cyc;
   logic [SW-1:0]    slot_q, cur_slot;
   logic             run_q;

   assign active   = run_q | frame_start;
   assign cur_cyc  = frame_start ? '0 : cyc_q;
   assign cur_slot = frame_start ? '0 : slot_q;
   assign slot     = cur_slot;
   assign first    = active && (cur_cyc == '0) && (cur_slot == '0);
   assign last     = active && (cur_cyc == CYC_LAST) && (cur_slot == SLOT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q  <= '0;
         slot_q <= '0;
         run_q  <= 1'b0;
      end else if (active) begin
         run_q <= 1'b1;
         if (cur_cyc == CYC_LAST) begin
            cyc_q  <= '0;
            slot_q <= (cur_slot == SLOT_LAST) ? '0 : cur_slot + 1'b1;
         end else begin
            cyc_q  <= cur_cyc + 1'b1;
            slot_q <= cur_slot;
         end
      end
   end

   // R2
   frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> (cyc_q == '0 && slot_q == '0 && run_q));
endmodule

// File: rtl/tem_edge_capture.sv
module tem_edge_capture
   import tem_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_in,
   input  logic              viol_in,
   input  logic              active,
   input  logic              first,
   input  logic [SLOT_W-1:0] slot,
   output tem_summary_t      summary
);
   localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(4);

   tem_summary_t acc_q, base, nxt;
   logic         prev_q;
   logic         edge_now;

   assign edge_now = active && (data_in ^ prev_q);

   always_comb begin
      base = first ? '0 : acc_q;
      nxt  = base;
      if (edge_now) begin
         case (base.n_edges)
            CNT_W'(0): nxt.pos1 = slot;
            CNT_W'(1): nxt.pos2 = slot;
            CNT_W'(2): nxt.pos3 = slot;
            default:   ;
         endcase
         if (base.n_edges != CNT_SAT) nxt.n_edges = base.n_edges + 1'b1;
      end
      if (active && viol_in && !base.viol_seen) begin
         nxt.viol_seen = 1'b1;
         nxt.viol_pos  = slot;
      end
      nxt.level = data_in;
   end

   assign summary = nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= data_in;
         if (active) acc_q <= nxt;
      end
   end

   // R5
   edge_count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q.n_edges <= CNT_SAT);
endmodule

// File: rtl/tem_frame_classifier.sv
module tem_frame_classifier
   import tem_pkg::*;
#(
   parameter int SPAN_SHORT = 13,
   parameter int SPAN_LONG  = 27,
   parameter int SPAN_TOL   = 1,
   parameter int FIRST2_MAX = 17,
   parameter int FIRST3_MAX = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         last,
   input  tem_summary_t summary,
   output logic [7:0]   word,
   output logic         word_valid
);
   localparam int SPLIT_W    = 2;
   localparam int LONG_SPLIT = 1 << SPLIT_W;
   localparam logic [5:0] SH_LO = 6'(SPAN_SHORT - SPAN_TOL);
   localparam logic [5:0] SH_HI = 6'(SPAN_SHORT + SPAN_TOL);
   localparam logic [5:0] LG_LO = 6'(SPAN_LONG - SPAN_TOL);
   localparam logic [5:0] LG_HI = 6'(SPAN_LONG + SPAN_TOL);
   localparam logic [SLOT_W-1:0] F2_MAX = SLOT_W'(FIRST2_MAX);
   localparam logic [SLOT_W-1:0] F3_MAX = SLOT_W'(FIRST3_MAX);
   localparam logic [SLOT_W-1:0] SPLIT  = SLOT_W'(LONG_SPLIT);

   if (SPAN_TOL < 0 || SPAN_SHORT + SPAN_TOL >= SPAN_LONG - SPAN_TOL) begin : g_bad_span
      $error("span windows overlap or tolerance negative");
   end
   if (SPAN_LONG - SPAN_TOL < 24 || SPAN_LONG + SPAN_TOL + LONG_SPLIT - 1 > 31) begin : g_bad_long
      $error("long span does not fit the split field");
   end

   logic [5:0] d12, d23;
   logic       sh12, sh23, lg12;

   assign d12 = {1'b0, summary.pos2} - {1'b0, summary.pos1};
   assign d23 = {1'b0, summary.pos3} - {1'b0, summary.pos2};

   if (SPAN_TOL == 0) begin : g_exact
      assign sh12 = (d12 == SH_LO);
      assign sh23 = (d23 == SH_LO);
      assign lg12 = (d12 == LG_LO);
   end else begin : g_window
      assign sh12 = (d12 >= SH_LO) && (d12 <= SH_HI);
      assign sh23 = (d23 >= SH_LO) && (d23 <= SH_HI);
      assign lg12 = (d12 >= LG_LO) && (d12 <= LG_HI);
   end

   logic [6:0] code;

   always_comb begin
      code = {2'b10, summary.pos1};
      case (summary.n_edges)
         CNT_W'(0): code = summary.viol_seen ? {2'b10, summary.viol_pos} : 7'h7F;
         CNT_W'(2): begin
            if (sh12 && summary.pos1 <= F2_MAX)
               code = {2'b11, summary.pos1};
            else if (lg12 && summary.pos1 >= SPLIT)
               code = {2'b01, summary.pos1};
            else if (lg12)
               code = {2'b00, summary.pos2[2:0], summary.pos1[SPLIT_W-1:0]};
         end
         CNT_W'(3): begin
            if (sh12 && sh23 && summary.pos1 <= F3_MAX)
               code = {2'b11, summary.pos1};
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word       <= 8'h00;
         word_valid <= 1'b0;
      end else begin
         word_valid <= last;
         if (last) word <= {summary.level, code};
      end
   end

   // R2
   valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> $past(last));
   // R7
   short_pair_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word[6:5] == 2'b11 && word[4:0] != 5'h1F) |-> (word[4:0] <= F2_MAX));
   // R9
   long_pair_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word[6:5] == 2'b01) |-> (word[4:0] >= SPLIT));
endmodule

// File: rtl/tem_encoder.sv
module tem_encoder #(
   parameter int SLOT_CYC   = 8,
   parameter int SLOTS      = 32,
   parameter int SPAN_SHORT = 13,
   parameter int SPAN_LONG  = 27,
   parameter int SPAN_TOL   = 1,
   parameter int FIRST2_MAX = 17,
   parameter int FIRST3_MAX = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_start,
   input  logic       data_in,
   input  logic       viol_in,
   output logic [7:0] word,
   output logic       word_valid
);
   import tem_pkg::*;

   if (SLOTS != (1 << SLOT_W)) begin : g_bad_frame
      $error("SLOTS must match the 5-bit position field");
   end

   logic              active, first, last;
   logic [SLOT_W-1:0] slot;
   tem_summary_t      summary;

   tem_slot_timer #(.SLOT_CYC(SLOT_CYC), .SLOTS(SLOTS)) u_timer (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .active(active), .first(first), .last(last), .slot(slot));

   tem_edge_capture u_capture (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .viol_in(viol_in),
      .active(active), .first(first), .slot(slot), .summary(summary));

   tem_frame_classifier #(
      .SPAN_SHORT(SPAN_SHORT), .SPAN_LONG(SPAN_LONG), .SPAN_TOL(SPAN_TOL),
      .FIRST2_MAX(FIRST2_MAX), .FIRST3_MAX(FIRST3_MAX)) u_class (
      .clk(clk), .rst_n(rst_n), .last(last), .summary(summary),
      .word(word), .word_valid(word_valid));

   // R2
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);
   // R3
   level_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (word[7] == $past(data_in)));
endmodule

// File: tb/tem_encoder_test.sv
module tem_encoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0;
   logic       data_in = 1'b0;
   logic       viol_in = 1'b0;
   logic [7:0] word;
   logic       word_valid;
   logic       lvl = 1'b0;
   int         n_checks = 0;
   int         n_fail = 0;

   always #2 clk = ~clk;

   tem_encoder uut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .data_in(data_in), .viol_in(viol_in),
      .word(word), .word_valid(word_valid));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one frame of 256 cycles; position args are timeslots, -1 for none
   task automatic run_frame(input bit strobe, input int e0, input int e1, input int e2,
                            input int e3, input int v0, input int v1,
                            input logic [6:0] exp_low, input string req);
      int spurious = 0;
      for (int i = 0; i < 256; i++) begin
         int s = i / 8;
         bit at = (i % 8) == 3;
         frame_start = strobe && (i == 0);
         if (at && (s == e0 || s == e1 || s == e2 || s == e3)) lvl = ~lvl;
         data_in = lvl;
         viol_in = at && (s == v0 || s == v1);
         @(posedge clk);
         @(negedge clk);
         if (i < 255 && word_valid) spurious++;
      end
      frame_start = 1'b0;
      viol_in = 1'b0;
      check(spurious == 0, "R2 valid only at frame end", spurious, 0);
      check(word_valid === 1'b1, "R2 valid pulse", word_valid, 1);
      check(word === {lvl, exp_low}, req, word, {lvl, exp_low});
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      check(word_valid === 1'b0 && word === 8'h00, "R1 reset state", word, 0);
      rst_n = 1'b1;
      repeat (300) @(negedge clk);
      check(word_valid === 1'b0 && word === 8'h00, "R1 R2 idle before first strobe", word, 0);
   endtask

   task automatic t_empty();
      run_frame(1, -1, -1, -1, -1, -1, -1, 7'h7F, "R4 no transition");
      run_frame(0, -1, -1, -1, -1, -1, -1, 7'h7F, "R2 free-running frame");
   endtask

   task automatic t_single();
      run_frame(1, 0, -1, -1, -1, -1, -1, 7'h40, "R5 single at slot 0");
      run_frame(1, 31, -1, -1, -1, -1, -1, 7'h5F, "R5 R3 single at slot 31");
      run_frame(1, 17, -1, -1, -1, -1, -1, 7'h51, "R5 single at slot 17");
   endtask

   task automatic t_violation();
      run_frame(1, -1, -1, -1, -1, 9, -1, 7'h49, "R6 violation at 9");
      run_frame(1, -1, -1, -1, -1, 5, 9, 7'h45, "R6 first violation kept");
      run_frame(1, 6, -1, -1, -1, 20, -1, 7'h46, "R6 violation ignored with data");
   endtask

   task automatic t_short();
      run_frame(1, 17, 30, -1, -1, -1, -1, 7'h71, "R7 pair first at 17");
      run_frame(1, 18, 31, -1, -1, -1, -1, 7'h52, "R11 pair first at 18");
      run_frame(1, 2, 16, -1, -1, -1, -1, 7'h62, "R7 gap 14 in window");
      run_frame(1, 2, 17, -1, -1, -1, -1, 7'h42, "R11 gap 15 outside");
      run_frame(1, 4, 17, 30, -1, -1, -1, 7'h64, "R8 triple first at 4");
      run_frame(1, 5, 18, 31, -1, -1, -1, 7'h45, "R11 triple first at 5");
   endtask

   task automatic t_long();
      run_frame(1, 4, 31, -1, -1, -1, -1, 7'h24, "R9 long pair first at 4");
      run_frame(1, 3, 30, -1, -1, -1, -1, 7'h1B, "R10 long pair first at 3");
      run_frame(1, 0, 27, -1, -1, -1, -1, 7'h0C, "R10 long pair first at 0");
      run_frame(1, 0, 13, 26, 30, -1, -1, 7'h40, "R11 four transitions");
   endtask

   task automatic t_restart();
      int spurious = 0;
      for (int i = 0; i < 100; i++) begin
         frame_start = (i == 0);
         if (i == 20) lvl = ~lvl;
         data_in = lvl;
         @(posedge clk);
         @(negedge clk);
         if (word_valid) spurious++;
      end
      check(spurious == 0, "R12 partial frame emits nothing", spurious, 0);
      run_frame(1, -1, -1, -1, -1, -1, -1, 7'h7F, "R12 restart discards partial");
   endtask

   initial begin
      #800000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_empty();
      t_single();
      t_violation();
      t_short();
      t_long();
      t_restart();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule